// File: doc/BRIEF.md
# Interrupt Trigger-Type Normalizer

This block sits between a set of wake-capable interrupt sources and a downstream interrupt controller that only understands two kinds of request: a one-cycle rising-edge pulse or an active-high level. Each input line is synchronized and then conditioned according to its own 3-bit trigger code. Active-low levels and falling edges are inverted, and a dual-edge code turns a change in either direction into a pulse. The result is a per-line request vector that the downstream controller can consume without knowing how each source signals.

Software programs the block through a small word-addressed register port. One bank holds packed per-line enable bits. A second bank holds one trigger-code word per line. Rewriting a line's trigger code moves the polarity inverter, and with the input held steady that would look like a fresh edge. The block absorbs that artefact, so a reconfiguration on its own never raises a request.

Top module: `irqnorm_top`

## Requirements
- R1: While reset is low and right after it, every request output is 0, every enable bit reads 0 and every trigger-code word reads 3'b100.
- R2: The enable bit of line n is bit n%32 of the word at byte address 0x10 + 4*(n/32). A write sets the enable bits of that word, and a read returns them.
- R3: The trigger code of line n lives in bits [2:0] of the word at byte address 0x110 + 4*n. Bits [31:3] read as zero.
- R4: Only the codes 3'b000, 3'b010, 3'b100, 3'b110 and 3'b111 are accepted. A write of any other code leaves the stored code unchanged.
- R5: Code 3'b100 (level, active high): the request equals the synchronized input. An input change that is sampled at clock edge k shows on the request after edge k+2.
- R6: Code 3'b000 (level, active low): the request equals the inverted synchronized input, with the same latency as R5.
- R7: Code 3'b110 (rising edge): each 0-to-1 input transition gives a request pulse exactly one cycle wide. A 1-to-0 transition gives none.
- R8: Code 3'b010 (falling edge): each 1-to-0 input transition gives a one-cycle request pulse. A 0-to-1 transition gives none.
- R9: Code 3'b111 (dual edge): every input transition, in either direction, gives a one-cycle request pulse.
- R10: A line whose enable bit is 0 never drives its request high, whatever its input or code.
- R11: A change of trigger code while the input is steady produces no edge request. Only an input transition after the write can produce one.
- R12: Enable bits above the last line and config offsets beyond the last line read as zero, and writes to them have no effect. An address whose bits [1:0] are not zero decodes to nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_in | input | NUM_LINES | Raw asynchronous interrupt inputs |
| irq_req | output | NUM_LINES | Conditioned requests: rising pulse or high level |

## Verification
An input change that is present before clock edge k reaches the request after edge k+2: two synchronizer flops and then the registered output. A register write at edge w changes the request that is computed at edge w+1, and read data follows the address within the same cycle. The bench drives every input at a falling edge. It samples requests and read data only at falling edges, so each latency check looks exactly two or three falling edges after the stimulus. A behavioural model advanced on every rising edge is also compared against the whole request vector at each falling edge.

// File: rtl/irqnorm_pkg.sv
package irqnorm_pkg;

   localparam int REG_W = 32;
   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      TRIG_LVL_LO = 3'b000,
      TRIG_FALL   = 3'b010,
      TRIG_LVL_HI = 3'b100,
      TRIG_RISE   = 3'b110,
      TRIG_BOTH   = 3'b111
   } trig_e;

   function automatic logic trig_valid(input logic [CODE_W-1:0] c);
      return (c == TRIG_LVL_LO) || (c == TRIG_FALL) || (c == TRIG_LVL_HI) ||
             (c == TRIG_RISE) || (c == TRIG_BOTH);
   endfunction

   // inversion applied before edge detection
   function automatic logic trig_invert(input logic [CODE_W-1:0] c);
      return (c == TRIG_LVL_LO) || (c == TRIG_FALL);
   endfunction

   function automatic logic trig_level(input logic [CODE_W-1:0] c);
      return (c == TRIG_LVL_LO) || (c == TRIG_LVL_HI);
   endfunction

   function automatic logic trig_dual(input logic [CODE_W-1:0] c);
      return c == TRIG_BOTH;
   endfunction

endpackage

// File: rtl/irqnorm_sync.sv
module irqnorm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("irqnorm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/irqnorm_regs.sv
module irqnorm_regs
   import irqnorm_pkg::*;
#(
   parameter int NUM_LINES = 168,
   parameter int ADDR_W    = 12,
   parameter int EN_BASE   = 'h10,
   parameter int CFG_BASE  = 'h110
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [REG_W-1:0]              wdata,
   output logic [REG_W-1:0]              rdata,
   output logic [NUM_LINES-1:0]          en_q,
   output logic [NUM_LINES-1:0][CODE_W-1:0] cfg_q,
   output logic [NUM_LINES-1:0][CODE_W-1:0] cfg_d
);

   localparam int NWORDS = (NUM_LINES + REG_W - 1) / REG_W;
   localparam int PAD_W  = NWORDS * REG_W;
   localparam int IDX_W  = ADDR_W - 2;
   localparam logic [IDX_W-1:0] EN_LO  = IDX_W'(EN_BASE / 4);
   localparam logic [IDX_W-1:0] EN_HI  = IDX_W'(EN_BASE / 4 + NWORDS);
   localparam logic [IDX_W-1:0] CFG_LO = IDX_W'(CFG_BASE / 4);
   localparam logic [IDX_W-1:0] CFG_HI = IDX_W'(CFG_BASE / 4 + NUM_LINES);

   generate
      if (NUM_LINES < 1) begin : g_bad_lines
         $error("irqnorm_regs: NUM_LINES must be positive");
      end
      if ((EN_BASE % 4) != 0 || (CFG_BASE % 4) != 0) begin : g_bad_align
         $error("irqnorm_regs: bank bases must be word aligned");
      end
      if (EN_BASE + 4 * NWORDS > CFG_BASE) begin : g_bad_overlap
         $error("irqnorm_regs: enable bank overlaps config bank");
      end
      if (CFG_BASE / 4 + NUM_LINES >= (1 << IDX_W)) begin : g_bad_span
         $error("irqnorm_regs: ADDR_W too small for config bank");
      end
   endgenerate

   logic [IDX_W-1:0] widx;
   logic             aligned;
   logic             en_hit;
   logic             cfg_hit;
   logic [IDX_W-1:0] en_sel;
   logic [IDX_W-1:0] cfg_sel;
   logic [PAD_W-1:0] en_pad;

   assign widx    = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign en_hit  = aligned && (widx >= EN_LO) && (widx < EN_HI);
   assign cfg_hit = aligned && (widx >= CFG_LO) && (widx < CFG_HI);
   assign en_sel  = widx - EN_LO;
   assign cfg_sel = widx - CFG_LO;

   // enable storage: real flops for real lines, constant zero padding
   genvar b;
   generate
      for (b = 0; b < PAD_W; b++) begin : g_en_bit
         if (b < NUM_LINES) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  en_q[b] <= 1'b0;
               else if (wr && en_hit && en_sel == IDX_W'(b / REG_W))
                  en_q[b] <= wdata[b % REG_W];
            end
            assign en_pad[b] = en_q[b];
         end else begin : g_pad
            assign en_pad[b] = 1'b0;
         end
      end
   endgenerate

   // trigger-code storage; next value exported for the lanes
   genvar n;
   generate
      for (n = 0; n < NUM_LINES; n++) begin : g_cfg
         logic take;
         assign take = wr && cfg_hit && (cfg_sel == IDX_W'(n)) &&
                       trig_valid(wdata[CODE_W-1:0]);
         assign cfg_d[n] = take ? wdata[CODE_W-1:0] : cfg_q[n];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cfg_q[n] <= TRIG_LVL_HI;
            else        cfg_q[n] <= cfg_d[n];
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NWORDS; w++) begin
         if (en_hit && en_sel == IDX_W'(w))
            rdata = en_pad[w*REG_W +: REG_W];
      end
      for (int c = 0; c < NUM_LINES; c++) begin
         if (cfg_hit && cfg_sel == IDX_W'(c))
            rdata = {{(REG_W-CODE_W){1'b0}}, cfg_q[c]};
      end
   end

endmodule

// File: rtl/irqnorm_lane.sv
module irqnorm_lane
   import irqnorm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raw,
   input  logic              en,
   input  logic [CODE_W-1:0] cfg_cur,
   input  logic [CODE_W-1:0] cfg_nxt,
   output logic              req
);

   logic s;
   logic pol;
   logic prev_q;
   logic hit;

   irqnorm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (s)
   );

   assign pol = s ^ trig_invert(cfg_cur);

   always_comb begin
      if (trig_level(cfg_cur))     hit = pol;
      else if (trig_dual(cfg_cur)) hit = pol ^ prev_q;
      else                         hit = pol & ~prev_q;
   end

   // history is taken under the polarity that applies next cycle,
   // so a code change alone never looks like a transition
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         req    <= 1'b0;
      end else begin
         prev_q <= s ^ trig_invert(cfg_nxt);
         req    <= en & hit;
      end
   end

endmodule

// File: rtl/irqnorm_top.sv
module irqnorm_top
   import irqnorm_pkg::*;
#(
   parameter int NUM_LINES   = 168,
   parameter int ADDR_W      = 12,
   parameter int EN_BASE     = 'h10,
   parameter int CFG_BASE    = 'h110,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic [NUM_LINES-1:0] irq_req
);

   logic [NUM_LINES-1:0]             line_en;
   logic [NUM_LINES-1:0][CODE_W-1:0] cfg_cur;
   logic [NUM_LINES-1:0][CODE_W-1:0] cfg_nxt;

   irqnorm_regs #(
      .NUM_LINES(NUM_LINES),
      .ADDR_W   (ADDR_W),
      .EN_BASE  (EN_BASE),
      .CFG_BASE (CFG_BASE)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (reg_wr),
      .addr (reg_addr),
      .wdata(reg_wdata),
      .rdata(reg_rdata),
      .en_q (line_en),
      .cfg_q(cfg_cur),
      .cfg_d(cfg_nxt)
   );

   genvar i;
   generate
      for (i = 0; i < NUM_LINES; i++) begin : g_lane
         irqnorm_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (irq_in[i]),
            .en     (line_en[i]),
            .cfg_cur(cfg_cur[i]),
            .cfg_nxt(cfg_nxt[i]),
            .req    (irq_req[i])
         );
      end
   endgenerate

endmodule

// File: rtl/irqnorm_checker.sv
module irqnorm_checker
   import irqnorm_pkg::*;
#(
   parameter int N = 168
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N-1:0]             irq_in,
   input logic [N-1:0]             irq_req,
   input logic [N-1:0]             line_en,
   input logic [N-1:0][CODE_W-1:0] cfg_cur
);

   logic [2:0] warm_q;
   logic       warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm_q <= 3'd0;
      else if (warm_q != 3'd4) warm_q <= warm_q + 3'd1;
   end
   assign warm = (warm_q == 3'd4);

   a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (irq_req == '0));

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_line
         a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[i] |-> $past(line_en[i]));

         a_r5_level_high: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && $past(cfg_cur[i]) == TRIG_LVL_HI) |->
               (irq_req[i] == ($past(line_en[i]) && $past(irq_in[i], 3))));

         a_r6_level_low: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && $past(cfg_cur[i]) == TRIG_LVL_LO) |->
               (irq_req[i] == ($past(line_en[i]) && !$past(irq_in[i], 3))));

         // covers R8 as well as R7
         a_r7_edge_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[i] &&
             ($past(cfg_cur[i]) == TRIG_RISE || $past(cfg_cur[i]) == TRIG_FALL) &&
             cfg_cur[i] == $past(cfg_cur[i])) |=> !irq_req[i]);

         a_r11_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && cfg_cur[i] != $past(cfg_cur[i]) &&
             (cfg_cur[i] == TRIG_RISE || cfg_cur[i] == TRIG_FALL ||
              cfg_cur[i] == TRIG_BOTH) &&
             $past(irq_in[i], 2) == $past(irq_in[i], 3)) |=> !irq_req[i]);
      end
   endgenerate

endmodule

bind irqnorm_top irqnorm_checker #(.N(NUM_LINES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .irq_in (irq_in),
   .irq_req(irq_req),
   .line_en(line_en),
   .cfg_cur(cfg_cur)
);

// File: tb/irqnorm_top_test.sv
module irqnorm_top_test;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 168;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NL-1:0] irq_in = '0;
   logic [NL-1:0] irq_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   irqnorm_top #(.NUM_LINES(NL), .ADDR_W(AW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .irq_in   (irq_in),
      .irq_req  (irq_req)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // ---------------- behavioural reference ----------------
   bit       m_en  [NL];
   bit [2:0] m_cfg [NL];
   bit       m_a1  [NL];
   bit       m_a2  [NL];
   bit       m_p   [NL];
   bit       m_out [NL];
   bit       m_nxt [NL];
   int       m_chg [NL];
   int       cyc = 0;

   function automatic bit f_inv(bit [2:0] c);
      return (c == 3'b000) || (c == 3'b010);
   endfunction

   function automatic bit f_ok(bit [2:0] c);
      return c == 3'b000 || c == 3'b010 || c == 3'b100 || c == 3'b110 || c == 3'b111;
   endfunction

   always @(posedge clk) begin : model
      int  w;
      int  ln;
      bit  v;
      bit  hit;
      if (!rst_n) begin
         for (int n = 0; n < NL; n++) begin
            m_en[n] = 0; m_cfg[n] = 3'b100; m_a1[n] = 0; m_a2[n] = 0;
            m_p[n] = 0; m_out[n] = 0; m_chg[n] = -100;
         end
      end else begin
         cyc++;
         for (int n = 0; n < NL; n++) begin
            v = m_a2[n] ^ f_inv(m_cfg[n]);
            if (m_cfg[n] == 3'b000 || m_cfg[n] == 3'b100) hit = v;
            else if (m_cfg[n] == 3'b111)                  hit = v ^ m_p[n];
            else                                          hit = v & ~m_p[n];
            m_nxt[n] = m_en[n] & hit;
         end
         if (reg_wr && reg_addr[1:0] == 2'b00) begin
            w = int'(reg_addr) / 4;
            if (w >= 4 && w < 10) begin
               for (int j = 0; j < 32; j++) begin
                  ln = (w - 4) * 32 + j;
                  if (ln < NL) m_en[ln] = reg_wdata[j];
               end
            end
            if (w >= 68 && w < 68 + NL && f_ok(reg_wdata[2:0])) begin
               if (m_cfg[w-68] != reg_wdata[2:0]) m_chg[w-68] = cyc;
               m_cfg[w-68] = reg_wdata[2:0];
            end
         end
         for (int n = 0; n < NL; n++) begin
            m_p[n]   = m_a2[n] ^ f_inv(m_cfg[n]);
            m_a2[n]  = m_a1[n];
            m_a1[n]  = irq_in[n];
            m_out[n] = m_nxt[n];
         end
      end
   end

   always @(negedge clk) begin : compare
      int bad;
      string tag;
      if (rst_n && !done) begin
         checks++;
         bad = -1;
         for (int n = NL - 1; n >= 0; n--)
            if (irq_req[n] !== m_out[n]) bad = n;
         if (bad >= 0) begin
            fails++;
            if (!m_en[bad])                     tag = "R10";
            else if (cyc - m_chg[bad] <= 3)     tag = "R11";
            else if (m_cfg[bad] == 3'b100)      tag = "R5";
            else if (m_cfg[bad] == 3'b000)      tag = "R6";
            else if (m_cfg[bad] == 3'b110)      tag = "R7";
            else if (m_cfg[bad] == 3'b010)      tag = "R8";
            else                                tag = "R9";
            $display("FAIL %s line %0d request actual=%0b expected=%0b",
                     tag, bad, irq_req[bad], m_out[bad]);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(string tag, logic [AW-1:0] a, logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic set_in(int line, logic val);
      @(negedge clk);
      irq_in[line] = val;
   endtask

   task automatic count_high(int line, int ncyc, output int cnt, output int maxw);
      int run = 0;
      cnt = 0; maxw = 0;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         if (irq_req[line]) begin
            cnt++; run++;
            if (run > maxw) maxw = run;
         end else run = 0;
      end
   endtask

   function automatic logic [AW-1:0] cfg_a(int n);
      return AW'(12'h110 + 4 * n);
   endfunction

   // ---------------- stimulus ----------------
   initial begin : main
      int cnt;
      int mw;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 requests idle", 32'(irq_req == '0), 32'd1);
      rd_check("R1 enable word", 12'h010, 32'h0);
      rd_check("R1 config default", cfg_a(5), 32'h4);

      // R2 enable packing
      wr(12'h010, 32'h0000_00FF);
      wr(12'h014, 32'h0000_0100);
      rd_check("R2 word0", 12'h010, 32'h0000_00FF);
      rd_check("R2 word1 line40", 12'h014, 32'h0000_0100);

      // R12 unused bits and offsets
      wr(12'h024, 32'hFFFF_FFFF);
      rd_check("R12 top word pad bits", 12'h024, 32'h0000_00FF);
      wr(12'h3B0, 32'h6);
      rd_check("R12 config past end", 12'h3B0, 32'h0);
      wr(12'h028, 32'hFFFF_FFFF);
      rd_check("R12 enable past end", 12'h028, 32'h0);
      rd_check("R12 misaligned", 12'h111, 32'h0);

      // R3 config word, upper bits dropped
      wr(cfg_a(3), 32'hFFFF_FFF7);
      rd_check("R3 config line3", cfg_a(3), 32'h7);
      // R4 unsupported codes
      wr(cfg_a(3), 32'h1);
      rd_check("R4 code 001 ignored", cfg_a(3), 32'h7);
      wr(cfg_a(3), 32'h5);
      rd_check("R4 code 101 ignored", cfg_a(3), 32'h7);

      wr(cfg_a(1), 32'h6);
      wr(cfg_a(2), 32'h2);
      wr(cfg_a(4), 32'h0);
      wr(cfg_a(9), 32'h6);
      repeat (5) @(negedge clk);

      // R6 active-low level
      check("R6 low input asserts", 32'(irq_req[4]), 32'd1);
      set_in(4, 1'b1);
      repeat (4) @(negedge clk);
      check("R6 high input clears", 32'(irq_req[4]), 32'd0);

      // R5 level-high latency
      set_in(0, 1'b1);
      @(negedge clk);
      @(negedge clk);
      check("R5 not yet after two edges", 32'(irq_req[0]), 32'd0);
      @(negedge clk);
      check("R5 asserted after third edge", 32'(irq_req[0]), 32'd1);
      set_in(0, 1'b0);
      repeat (4) @(negedge clk);
      check("R5 released", 32'(irq_req[0]), 32'd0);

      // R7 rising edge
      set_in(1, 1'b1);
      count_high(1, 8, cnt, mw);
      check("R7 rise pulse count", 32'(cnt), 32'd1);
      check("R7 rise pulse width", 32'(mw), 32'd1);
      set_in(1, 1'b0);
      count_high(1, 8, cnt, mw);
      check("R7 no pulse on fall", 32'(cnt), 32'd0);

      // R8 falling edge
      set_in(2, 1'b1);
      count_high(2, 8, cnt, mw);
      check("R8 no pulse on rise", 32'(cnt), 32'd0);
      set_in(2, 1'b0);
      count_high(2, 8, cnt, mw);
      check("R8 fall pulse count", 32'(cnt), 32'd1);

      // R9 dual edge
      set_in(3, 1'b1);
      count_high(3, 6, cnt, mw);
      check("R9 pulse on rise", 32'(cnt), 32'd1);
      set_in(3, 1'b0);
      count_high(3, 6, cnt, mw);
      check("R9 pulse on fall", 32'(cnt), 32'd1);

      // R10 disabled line
      set_in(9, 1'b1);
      count_high(9, 8, cnt, mw);
      check("R10 disabled rising line", 32'(cnt), 32'd0);
      wr(cfg_a(9), 32'h4);
      count_high(9, 6, cnt, mw);
      check("R10 disabled level line", 32'(cnt), 32'd0);

      // R11 reconfiguration with steady input
      wr(cfg_a(7), 32'h6);
      repeat (4) @(negedge clk);
      wr(cfg_a(7), 32'h2);
      count_high(7, 8, cnt, mw);
      check("R11 rise->fall input low", 32'(cnt), 32'd0);
      wr(cfg_a(7), 32'h0);
      set_in(7, 1'b1);
      repeat (5) @(negedge clk);
      wr(cfg_a(7), 32'h6);
      count_high(7, 8, cnt, mw);
      check("R11 low-level->rise input high", 32'(cnt), 32'd0);
      wr(cfg_a(7), 32'h7);
      count_high(7, 8, cnt, mw);
      check("R11 rise->dual input high", 32'(cnt), 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : watchdog
      #(CLK_PERIOD * 50000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule